// File: doc/BRIEF.md
# Multi-port RAM array with per-port read modes

This block is a word-addressed storage array with any number of read ports and write ports. Each port has its own clock and its own choice of clock edge. Each read port is set at elaboration time to one of three behaviours:
- **Combinational:** the output follows the address with no register.
- **Registered data:** the addressed word is captured into an output register on the active edge.
- **Registered address:** only the address is captured, and the output is read combinationally from the array at that held address. A write to that word on the same edge therefore shows on the output at once.

Write ports carry one enable bit per data bit, so any group of bits inside a word can be updated without touching the others.

All port signals are flat vectors with one slice per port. The address window starts at a configurable base, and the array can be preloaded from a parameter vector. Internally, every write port owns a private bank that only its own clock writes. A word's value is the XOR of all banks at that slot. Ports on unrelated clocks therefore never drive the same storage element.

The reset input clears only the read-side registers. The stored contents keep their preload values or last writes.

Top module: `mpram`

## Requirements
- R1: Read port i uses `rd_addr[i*ABITS +: ABITS]`, `rd_data[i*WIDTH +: WIDTH]` and clock `rd_clk[i]`. Write port i uses `wr_addr`, `wr_data` and `wr_en` slices at the same positions, and clock `wr_clk[i]`.
- R2: With `PRELOAD` set, the word at slot k starts as `INIT[k*WIDTH +: WIDTH]`.
- R3: A read port whose `RD_CLOCKED` bit is 0 is combinational: its data always shows the word at its present address.
- R4: A read port with `RD_CLOCKED`=1 and `RD_ADDR_REG`=0 loads the addressed word into its output register on its active edge. A write to that word on the same edge is not seen until the next active edge.
- R5: A read port with `RD_CLOCKED`=1 and `RD_ADDR_REG`=1 registers its address on its active edge. Its data is the array word at the held address, so writes to that word appear without waiting for another edge of the read port, including a write on the same edge.
- R6: Bit i of `RD_RISE` / `WR_RISE` set to 1 makes port i act on the rising edge of its clock. Set to 0, the port acts on the falling edge.
- R7: On a write port's active edge, a bit of the addressed word takes `wr_data` where its `wr_en` bit is 1 and keeps its value where the bit is 0.
- R8: Address a maps to slot a − `OFFSET`. Reads of addresses outside [`OFFSET`, `OFFSET`+`SIZE`−1] return all zeros, and writes to such addresses change nothing.
- R9: While `rst_n` is low, every registered read data output is zero and every registered read address is zero.
- R10: Two write ports writing disjoint bit groups of one word on their own edges both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of read-side registers |
| rd_clk | input | NRD | One clock per read port |
| rd_addr | input | NRD*ABITS | Read addresses, one slice per port |
| rd_data | output | NRD*WIDTH | Read data, one slice per port |
| wr_clk | input | NWR | One clock per write port |
| wr_en | input | NWR*WIDTH | Per-bit write enables, one slice per port |
| wr_addr | input | NWR*ABITS | Write addresses, one slice per port |
| wr_data | input | NWR*WIDTH | Write data, one slice per port |

## Verification
The bench aims at the points where the read modes split apart:
- **Same-edge read and write.** A registered-data port reading a word that is written on the same edge must still show the old value. A design that forwarded the write would show the new one a cycle early. A registered-address port in the same situation must show the new value at once, and a design that registered the data instead would lag by a full cycle.
- **Opposite-edge clocking.** Ports on opposite edges are driven from one clock, so a design with inverted polarity handling moves the output half a cycle off.
- **Masks and address window.** Masked writes and two ports splitting one word would expose wrong or leaking bits. Addresses just outside the window would expose aliasing onto valid words.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  typedef enum logic [1:0] {
    RM_COMB     = 2'd0,
    RM_DATA_REG = 2'd1,
    RM_ADDR_REG = 2'd2
  } rmode_e;

  // An unclocked read port is combinational whatever its address-register bit says.
  function automatic rmode_e pick_mode(input bit clocked, input bit addr_reg);
    if (!clocked) return RM_COMB;
    return addr_reg ? RM_ADDR_REG : RM_DATA_REG;
  endfunction

  function automatic bit in_window(input longint unsigned a,
                                   input longint unsigned base,
                                   input longint unsigned n);
    return (a >= base) && (a < base + n);
  endfunction

  function automatic longint unsigned slot_of(input longint unsigned a,
                                              input longint unsigned base);
    return a - base;
  endfunction

endpackage

// File: rtl/mpram_wbank.sv
module mpram_wbank #(
  parameter int   WIDTH   = 8,
  parameter int   SIZE    = 10,
  parameter int   IW      = 4,
  parameter int   NQ      = 5,
  parameter bit   RISE    = 1'b1,
  parameter bit   PRELOAD = 1'b0,
  parameter logic [SIZE*WIDTH-1:0] INIT = '0
) (
  input  logic                clk,
  input  logic                fire,
  input  logic [IW-1:0]       widx,
  input  logic [WIDTH-1:0]    wmask,
  input  logic [WIDTH-1:0]    wdata,
  input  logic [WIDTH-1:0]    peer_xor,
  input  logic [NQ*IW-1:0]    q_idx,
  output logic [NQ*WIDTH-1:0] q_word
);
  logic [WIDTH-1:0] cells [SIZE];

  // Stored value is chosen so that XOR with every other bank yields wdata.
  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old_v,
                                             input logic [WIDTH-1:0] d,
                                             input logic [WIDTH-1:0] m,
                                             input logic [WIDTH-1:0] p);
    return (old_v & ~m) | ((d ^ p) & m);
  endfunction

  initial begin
    for (int k = 0; k < SIZE; k++)
      cells[k] = PRELOAD ? INIT[k*WIDTH +: WIDTH] : '0;
  end

  if (RISE) begin : g_rise
    always_ff @(posedge clk)
      if (fire) cells[widx] <= merge(cells[widx], wdata, wmask, peer_xor);
  end else begin : g_fall
    always_ff @(negedge clk)
      if (fire) cells[widx] <= merge(cells[widx], wdata, wmask, peer_xor);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_word[q*WIDTH +: WIDTH] = cells[q_idx[q*IW +: IW]];
  end

endmodule

// File: rtl/mpram_rport.sv
module mpram_rport #(
  parameter int ABITS = 4,
  parameter int WIDTH = 8,
  parameter mpram_pkg::rmode_e MODE = mpram_pkg::RM_COMB,
  parameter bit RISE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ABITS-1:0] addr,
  output logic [ABITS-1:0] look_addr,
  input  logic [WIDTH-1:0] look_word,
  output logic [WIDTH-1:0] data
);
  import mpram_pkg::*;

  if (MODE == RM_COMB) begin : g_comb
    logic unused_pins;
    assign unused_pins = clk ^ rst_n;
    assign look_addr   = addr;
    assign data        = look_word;
  end else if (MODE == RM_DATA_REG) begin : g_dreg
    logic [WIDTH-1:0] data_q;
    assign look_addr = addr;
    assign data      = data_q;
    if (RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) data_q <= '0;
        else        data_q <= look_word;
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n)
        if (!rst_n) data_q <= '0;
        else        data_q <= look_word;
    end
  end else begin : g_areg
    logic [ABITS-1:0] addr_q;
    assign look_addr = addr_q;
    assign data      = look_word;
    if (RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr;
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n)
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr;
    end
  end

endmodule

// File: rtl/mpram.sv
module mpram #(
  parameter int ABITS  = 4,
  parameter int SIZE   = 10,
  parameter int WIDTH  = 8,
  parameter int OFFSET = 3,
  parameter int NRD    = 3,
  parameter int NWR    = 2,
  parameter logic [NRD-1:0] RD_CLOCKED  = 3'b110,
  parameter logic [NRD-1:0] RD_ADDR_REG = 3'b100,
  parameter logic [NRD-1:0] RD_RISE     = 3'b011,
  parameter logic [NWR-1:0] WR_RISE     = 2'b01,
  parameter bit             PRELOAD     = 1'b0,
  parameter logic [SIZE*WIDTH-1:0] INIT = '0
) (
  input  logic                 rst_n,
  input  logic [NRD-1:0]       rd_clk,
  input  logic [NRD*ABITS-1:0] rd_addr,
  output logic [NRD*WIDTH-1:0] rd_data,
  input  logic [NWR-1:0]       wr_clk,
  input  logic [NWR*WIDTH-1:0] wr_en,
  input  logic [NWR*ABITS-1:0] wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data
);
  import mpram_pkg::*;

  localparam int IW = (SIZE > 1) ? $clog2(SIZE) : 1;
  localparam int NQ = NRD + NWR;   // queries: read ports first, then write ports

  logic [NQ*ABITS-1:0]       q_addr;
  logic [NQ*IW-1:0]          q_idx;
  logic [NQ-1:0]             q_ok;
  logic [NWR*NQ*WIDTH-1:0]   bank_word;
  logic [NQ*WIDTH-1:0]       look_word;
  logic [NWR-1:0]            wr_fire;

  // Address window and slot per query
  for (genvar q = 0; q < NQ; q++) begin : g_win
    assign q_ok[q] = in_window(64'(q_addr[q*ABITS +: ABITS]), 64'(OFFSET), 64'(SIZE));
    assign q_idx[q*IW +: IW] =
      q_ok[q] ? IW'(slot_of(64'(q_addr[q*ABITS +: ABITS]), 64'(OFFSET))) : '0;
  end

  // Word value is the XOR of all banks; outside the window it reads zero
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      logic [WIDTH-1:0] acc;
      acc = '0;
      for (int b = 0; b < NWR; b++)
        acc ^= bank_word[(b*NQ + q)*WIDTH +: WIDTH];
      look_word[q*WIDTH +: WIDTH] = q_ok[q] ? acc : '0;
    end
  end

  // Read ports
  for (genvar i = 0; i < NRD; i++) begin : g_rd
    mpram_rport #(
      .ABITS (ABITS),
      .WIDTH (WIDTH),
      .MODE  (pick_mode(RD_CLOCKED[i], RD_ADDR_REG[i])),
      .RISE  (RD_RISE[i])
    ) u_rport (
      .clk       (rd_clk[i]),
      .rst_n     (rst_n),
      .addr      (rd_addr[i*ABITS +: ABITS]),
      .look_addr (q_addr[i*ABITS +: ABITS]),
      .look_word (look_word[i*WIDTH +: WIDTH]),
      .data      (rd_data[i*WIDTH +: WIDTH])
    );
  end

  // Write ports, one private bank each
  for (genvar p = 0; p < NWR; p++) begin : g_wr
    localparam int QP = NRD + p;
    logic [WIDTH-1:0] peer;

    assign q_addr[QP*ABITS +: ABITS] = wr_addr[p*ABITS +: ABITS];
    assign wr_fire[p] = (|wr_en[p*WIDTH +: WIDTH]) && q_ok[QP];
    // XOR of the other banks = full XOR with own bank removed
    assign peer = look_word[QP*WIDTH +: WIDTH] ^ bank_word[(p*NQ + QP)*WIDTH +: WIDTH];

    mpram_wbank #(
      .WIDTH   (WIDTH),
      .SIZE    (SIZE),
      .IW      (IW),
      .NQ      (NQ),
      .RISE    (WR_RISE[p]),
      .PRELOAD (PRELOAD && (p == 0)),
      .INIT    (INIT)
    ) u_bank (
      .clk      (wr_clk[p]),
      .fire     (wr_fire[p]),
      .widx     (q_idx[QP*IW +: IW]),
      .wmask    (wr_en[p*WIDTH +: WIDTH]),
      .wdata    (wr_data[p*WIDTH +: WIDTH]),
      .peer_xor (peer),
      .q_idx    (q_idx),
      .q_word   (bank_word[p*NQ*WIDTH +: NQ*WIDTH])
    );
  end

endmodule

// File: rtl/mpram_chk.sv
module mpram_chk #(
  parameter int ABITS  = 4,
  parameter int SIZE   = 10,
  parameter int WIDTH  = 8,
  parameter int OFFSET = 3,
  parameter int NRD    = 3,
  parameter int NWR    = 2,
  parameter logic [NRD-1:0] RD_CLOCKED  = 3'b110,
  parameter logic [NRD-1:0] RD_ADDR_REG = 3'b100,
  parameter logic [NRD-1:0] RD_RISE     = 3'b011,
  parameter logic [NWR-1:0] WR_RISE     = 2'b01
) (
  input logic                       rst_n,
  input logic [NRD-1:0]             rd_clk,
  input logic [NRD*ABITS-1:0]       rd_addr,
  input logic [NRD*WIDTH-1:0]       rd_data,
  input logic [NWR-1:0]             wr_clk,
  input logic [NWR*WIDTH-1:0]       wr_en,
  input logic [NWR*ABITS-1:0]       wr_addr,
  input logic [NWR*WIDTH-1:0]       wr_data,
  input logic [(NRD+NWR)*ABITS-1:0] q_addr,
  input logic [NRD+NWR-1:0]         q_ok,
  input logic [(NRD+NWR)*WIDTH-1:0] look_word
);
  import mpram_pkg::*;

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    localparam rmode_e M = pick_mode(RD_CLOCKED[i], RD_ADDR_REG[i]);
    if (M == RM_COMB) begin : g_comb
      a_r8_outside_reads_zero: assert property (@(posedge rd_clk[i]) disable iff (!rst_n)
        !q_ok[i] |-> rd_data[i*WIDTH +: WIDTH] == '0);
    end else if (M == RM_DATA_REG) begin : g_dreg
      if (RD_RISE[i]) begin : g_rise
        a_r4_data_capture: assert property (@(posedge rd_clk[i]) disable iff (!rst_n)
          rst_n |=> rd_data[i*WIDTH +: WIDTH] == $past(look_word[i*WIDTH +: WIDTH]));
      end else begin : g_fall
        a_r4_data_capture: assert property (@(negedge rd_clk[i]) disable iff (!rst_n)
          rst_n |=> rd_data[i*WIDTH +: WIDTH] == $past(look_word[i*WIDTH +: WIDTH]));
      end
    end else begin : g_areg
      if (RD_RISE[i]) begin : g_rise
        a_r5_addr_capture: assert property (@(posedge rd_clk[i]) disable iff (!rst_n)
          rst_n |=> q_addr[i*ABITS +: ABITS] == $past(rd_addr[i*ABITS +: ABITS]));
      end else begin : g_fall
        a_r5_addr_capture: assert property (@(negedge rd_clk[i]) disable iff (!rst_n)
          rst_n |=> q_addr[i*ABITS +: ABITS] == $past(rd_addr[i*ABITS +: ABITS]));
      end
    end
  end

  // R7: a full-word write is readable half a clock later while the address is held
  for (genvar p = 0; p < NWR; p++) begin : g_wr
    localparam int QP = NRD + p;
    logic             arm;
    logic [ABITS-1:0] a_cap;
    logic [WIDTH-1:0] d_cap;
    logic             take;
    assign take = (&wr_en[p*WIDTH +: WIDTH]) && q_ok[QP];

    if (WR_RISE[p]) begin : g_rise
      always_ff @(posedge wr_clk[p] or negedge rst_n)
        if (!rst_n) begin
          arm <= 1'b0; a_cap <= '0; d_cap <= '0;
        end else begin
          arm <= take; a_cap <= wr_addr[p*ABITS +: ABITS]; d_cap <= wr_data[p*WIDTH +: WIDTH];
        end
      a_r7_written_bits_land: assert property (@(negedge wr_clk[p]) disable iff (!rst_n)
        (arm && wr_addr[p*ABITS +: ABITS] == a_cap) |-> look_word[QP*WIDTH +: WIDTH] == d_cap);
    end else begin : g_fall
      always_ff @(negedge wr_clk[p] or negedge rst_n)
        if (!rst_n) begin
          arm <= 1'b0; a_cap <= '0; d_cap <= '0;
        end else begin
          arm <= take; a_cap <= wr_addr[p*ABITS +: ABITS]; d_cap <= wr_data[p*WIDTH +: WIDTH];
        end
      a_r7_written_bits_land: assert property (@(posedge wr_clk[p]) disable iff (!rst_n)
        (arm && wr_addr[p*ABITS +: ABITS] == a_cap) |-> look_word[QP*WIDTH +: WIDTH] == d_cap);
    end
  end

endmodule

bind mpram mpram_chk #(
  .ABITS(ABITS), .SIZE(SIZE), .WIDTH(WIDTH), .OFFSET(OFFSET), .NRD(NRD), .NWR(NWR),
  .RD_CLOCKED(RD_CLOCKED), .RD_ADDR_REG(RD_ADDR_REG), .RD_RISE(RD_RISE), .WR_RISE(WR_RISE)
) u_chk (.*);

// File: tb/mpram_bench.sv
module mpram_bench;
  localparam int ABITS = 4, SIZE = 10, WIDTH = 8, OFFSET = 3, NRD = 3, NWR = 2;

  function automatic logic [SIZE*WIDTH-1:0] mk_init();
    logic [SIZE*WIDTH-1:0] v;
    for (int k = 0; k < SIZE; k++) v[k*WIDTH +: WIDTH] = 8'(k*37 + 5);
    return v;
  endfunction
  localparam logic [SIZE*WIDTH-1:0] INIT_V = mk_init();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NRD*ABITS-1:0] rd_addr = '0;
  logic [NRD*WIDTH-1:0] rd_data;
  logic [NWR*WIDTH-1:0] wr_en = '0;
  logic [NWR*ABITS-1:0] wr_addr = '0;
  logic [NWR*WIDTH-1:0] wr_data = '0;
  logic [NRD-1:0] rd_clk;
  logic [NWR-1:0] wr_clk;
  assign rd_clk = {NRD{clk}};
  assign wr_clk = {NWR{clk}};

  always #4 clk = ~clk;   // 125 MHz

  // Port 0 combinational, port 1 registered data on rising edge,
  // port 2 registered address on falling edge; write 0 rising, write 1 falling.
  mpram #(
    .ABITS(ABITS), .SIZE(SIZE), .WIDTH(WIDTH), .OFFSET(OFFSET), .NRD(NRD), .NWR(NWR),
    .RD_CLOCKED(3'b110), .RD_ADDR_REG(3'b100), .RD_RISE(3'b011), .WR_RISE(2'b01),
    .PRELOAD(1'b1), .INIT(INIT_V)
  ) u_mpram (
    .rst_n(rst_n), .rd_clk(rd_clk), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model [SIZE];

  function automatic logic [WIDTH-1:0] expect_at(input int a);
    if (a >= OFFSET && a < OFFSET + SIZE) return model[a - OFFSET];
    return '0;
  endfunction

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic at_pos(); @(posedge clk); #1; endtask
  task automatic at_neg(); @(negedge clk); #1; endtask

  task automatic wr(input int p, input int a, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] m);
    wr_addr[p*ABITS +: ABITS] = 4'(a);
    wr_data[p*WIDTH +: WIDTH] = d;
    wr_en[p*WIDTH +: WIDTH]   = m;
    if (p == 0) at_pos(); else at_neg();
    wr_en[p*WIDTH +: WIDTH] = '0;
    if (a >= OFFSET && a < OFFSET + SIZE)
      model[a - OFFSET] = (model[a - OFFSET] & ~m) | (d & m);
  endtask

  task automatic peek(input int a, output logic [WIDTH-1:0] v);
    rd_addr[0 +: ABITS] = 4'(a);
    #1;
    v = rd_data[0 +: WIDTH];
  endtask

  task automatic sweep(input string tag);
    logic [WIDTH-1:0] v;
    for (int a = 0; a < (1 << ABITS); a++) begin
      peek(a, v);
      check(tag, v, expect_at(a));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] v, old_v;
    for (int k = 0; k < SIZE; k++) model[k] = INIT_V[k*WIDTH +: WIDTH];

    // R9: reset clears registered outputs
    repeat (3) at_pos();
    check("R9 reg-data port in reset", rd_data[8 +: 8], 8'h00);
    check("R9 reg-addr port in reset", rd_data[16 +: 8], 8'h00);
    rst_n = 1'b1;

    // R2 R3 R8: preload contents and window through the combinational port
    sweep("R2 R3 R8 preload sweep");

    // R4: capture only on the rising edge
    at_pos();
    rd_addr[4 +: 4] = 4'd5;
    at_neg();
    check("R4 reg-data holds before edge", rd_data[8 +: 8], 8'h00);
    at_pos();
    check("R4 reg-data after edge", rd_data[8 +: 8], expect_at(5));

    // R4: same-edge write gives the old word, then the new one
    rd_addr[4 +: 4] = 4'd6;
    old_v = expect_at(6);
    wr(0, 6, 8'hC3, 8'hFF);
    check("R4 read-before-write old value", rd_data[8 +: 8], old_v);
    at_pos();
    check("R4 new value next edge", rd_data[8 +: 8], 8'hC3);

    // R5 R6: registered address on the falling edge
    rd_addr[8 +: 4] = 4'd7;
    #1;
    check("R5 reg-addr not combinational", rd_data[16 +: 8], 8'h00);
    at_neg();
    check("R5 reg-addr after falling edge", rd_data[16 +: 8], expect_at(7));
    rd_addr[8 +: 4] = 4'd8;
    at_pos();
    check("R6 falling-edge port ignores rising edge", rd_data[16 +: 8], expect_at(7));
    at_neg();
    check("R6 falling-edge port moves on falling edge", rd_data[16 +: 8], expect_at(8));

    // R5: same-edge write is visible, later writes follow
    rd_addr[8 +: 4] = 4'd9;
    wr(1, 9, 8'h5A, 8'hFF);
    check("R5 same-edge write visible", rd_data[16 +: 8], 8'h5A);
    wr(0, 9, 8'h11, 8'hF0);
    check("R5 later write follows", rd_data[16 +: 8], 8'h1A);

    // R7: masked writes
    wr(0, 10, 8'hFF, 8'h0F);
    peek(10, v); check("R7 low nibble set", v, expect_at(10));
    wr(1, 10, 8'h00, 8'h81);
    peek(10, v); check("R7 edge bits cleared", v, expect_at(10));

    // R10: two ports split one word
    wr(0, 11, 8'hAB, 8'h0F);
    wr(1, 11, 8'hCD, 8'hF0);
    peek(11, v); check("R10 split word", v, 8'hCB);

    // R8: writes outside the window change nothing
    wr(0, 13, 8'hFF, 8'hFF);
    wr(1, 2, 8'hFF, 8'hFF);
    wr(0, 15, 8'hEE, 8'hFF);
    wr(1, 0, 8'h77, 8'hFF);
    sweep("R8 outside writes ignored");

    // R7 R10: masked sweep over every slot from both ports
    for (int pass = 0; pass < 4; pass++) begin
      for (int a = OFFSET; a < OFFSET + SIZE; a++) begin
        logic [WIDTH-1:0] m;
        case (pass)
          0: m = 8'hFF;
          1: m = 8'h3C;
          2: m = 8'hA5;
          default: m = 8'(1 << (a % 8));
        endcase
        wr(pass & 1, a, 8'(a*29 + pass*71), m);
      end
      sweep("R7 R10 masked sweep");
    end

    // R1 R4 R5: every address through the clocked ports
    for (int a = 0; a < (1 << ABITS); a++) begin
      rd_addr[4 +: 4] = 4'(a);
      rd_addr[8 +: 4] = 4'(a);
      at_pos();
      check("R1 R4 port 1 slice", rd_data[8 +: 8], expect_at(a));
      at_neg();
      check("R1 R5 port 2 slice", rd_data[16 +: 8], expect_at(a));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule